// File: doc/BRIEF.md
# Decoupled Burst Memory Copy Engine

The engine copies a block of 32-bit words from one memory region to another and transforms each word on the way. Software writes a source begin address, a source end address and a destination address, all as byte addresses, and then writes the start bit. A read master fetches the source in bursts into a first-word-fall-through FIFO. Each word passes through a combinational transform into a second FIFO of the same kind. A write master drains that FIFO to the destination in bursts.

The two masters never signal each other. The read master looks only at the used-word counts of both FIFOs and at its own count of words that have been requested but have not yet returned. The write master looks only at the used-word count of the second FIFO. A done bit reports when the last word has been written.

Top module: `mcopy_engine`

## Requirements
- R1: The word count is end_word − begin_word + 1, where a word index is a byte address with its two low bits dropped and the end address names the last word copied. If the end word is below the begin word, the count is zero: no request is issued, busy stays low, and done_o is high in the cycle after the start write.
- R2: Register select 0 is the source begin, 1 is the source end and 2 is the destination. Each holds a full-width value and reads back what was written. Writing select 3 with bit 0 = 1 requests a start. Reading select 3 returns busy in bit 0 and done in bit 1, with all other bits zero.
- R3: Read requests cover consecutive words from the begin word, and write commands cover consecutive words from the destination word. Each burst carries min(BURST, words left), so only the last burst can be short. A request that is not accepted keeps its address and length stable.
- R4: A read burst of length L starts only when DEPTH − used(FIFO A) − outstanding ≥ L and DEPTH − used(FIFO B) ≥ L. Returned read data never overflows FIFO A, and neither FIFO underflows.
- R5: A write command of length L is raised only when used(FIFO B) ≥ L. Once the command is accepted, write data is valid for exactly L handshakes, and each handshake carries the head of FIFO B.
- R6: The word written at destination word d+i equals T(source word s+i). T keeps bits 31:24 and 7:0 unchanged and sets out[8+k] = in[23−k] for k = 0..15.
- R7: The read side runs while the write side is stalled. With write commands held unaccepted, the read master still requests at least DEPTH and at most 2·DEPTH words.
- R8: done_o and status bit 1 rise in the cycle after the final write-data handshake, and busy falls in that same cycle. An accepted start with a nonzero count clears done and sets busy in the next cycle.
- R9: A start write while busy is ignored. The running copy keeps the addresses and count it latched at its own start.
- R10: After reset, done, busy and every request and valid output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data for the current select (combinational) |
| rd_req_valid_o | output | 1 | Read burst request valid |
| rd_req_ready_i | input | 1 | Read burst request accepted |
| rd_req_addr_o | output | AW | Read burst byte address |
| rd_req_len_o | output | LW | Read burst length in words |
| rd_rsp_valid_i | input | 1 | Returned read word valid |
| rd_rsp_data_i | input | DW | Returned read word |
| wr_req_valid_o | output | 1 | Write burst command valid |
| wr_req_ready_i | input | 1 | Write burst command accepted |
| wr_req_addr_o | output | AW | Write burst byte address |
| wr_req_len_o | output | LW | Write burst length in words |
| wr_dat_valid_o | output | 1 | Write data valid |
| wr_dat_ready_i | input | 1 | Write data accepted |
| wr_dat_o | output | DW | Write data word |
| done_o | output | 1 | Copy complete |

## Verification
Most internal faults show up as a bad request address or length on the next accepted burst. A wrong outstanding count or a wrong room check either overflows FIFO A within one burst of returned data or stalls the read side. A stall leaves done_o low, and the bench reports it at its timeout. A fault in the transform or in the FIFO pointers corrupts the very next write-data word. A missed or late completion moves done_o off the cycle right after the final write handshake.

// File: rtl/mcopy_pkg.sv
package mcopy_pkg;
  typedef enum logic [1:0] {
    REG_SRC_BEG = 2'd0,
    REG_SRC_END = 2'd1,
    REG_DST     = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  localparam int CTRL_START_BIT = 0;
endpackage

// File: rtl/mcopy_fifo.sv
module mcopy_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] used_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] used_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      used_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   used_q <= used_q + CW'(1);
        2'b01:   used_q <= used_q - CW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  // fall-through: head word visible whenever used_o != 0
  assign data_o = mem_q[rp_q];
  assign used_o = used_q;

  // R4
  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (used_q != CW'(DEPTH) || pop_i));
  // R4
  fifo_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> used_q != '0);
endmodule

// File: rtl/mcopy_xform.sv
module mcopy_xform #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] word_o
);
  localparam int LO = 8;
  localparam int HI = 23;
  localparam int NR = HI - LO + 1;

  for (genvar k = 0; k < NR; k++) begin : g_rev
    assign word_o[LO+k] = word_i[HI-k];
  end
  assign word_o[LO-1:0]    = word_i[LO-1:0];
  assign word_o[DW-1:HI+1] = word_i[DW-1:HI+1];
endmodule

// File: rtl/mcopy_rd_master.sv
module mcopy_rd_master #(
  parameter int AW    = 32,
  parameter int BURST = 8,
  parameter int DEPTH = 16,
  localparam int PW   = AW - 2,
  localparam int NW   = AW - 1,
  localparam int LW   = $clog2(BURST + 1),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] base_w_i,
  input  logic [NW-1:0] words_i,
  input  logic [CW-1:0] used_a_i,
  input  logic [CW-1:0] used_b_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [LW-1:0] req_len_o,
  input  logic          rsp_valid_i
);
  logic [NW-1:0] left_q;
  logic [PW-1:0] ptr_q;
  logic [CW-1:0] out_q;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] blen;
  logic [RW-1:0] room_a, room_b;
  logic          launch;

  assign blen   = (left_q < NW'(BURST)) ? LW'(left_q) : LW'(BURST);
  assign room_a = RW'(DEPTH) - RW'(used_a_i) - RW'(out_q);
  assign room_b = RW'(DEPTH) - RW'(used_b_i);
  // outstanding words are reserved in FIFO A at launch time
  assign launch = !req_q && (left_q != '0) && (room_a >= RW'(blen)) && (room_b >= RW'(blen));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      ptr_q  <= '0;
      out_q  <= '0;
      req_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      out_q <= out_q + (launch ? CW'(blen) : CW'(0)) - (rsp_valid_i ? CW'(1) : CW'(0));
      if (start_i) begin
        left_q <= words_i;
        ptr_q  <= base_w_i;
      end else if (launch) begin
        left_q <= left_q - NW'(blen);
        ptr_q  <= ptr_q + PW'(blen);
      end
      if (launch) begin
        req_q  <= 1'b1;
        addr_q <= {ptr_q, 2'b00};
        len_q  <= blen;
      end else if (req_q && req_ready_i) begin
        req_q <= 1'b0;
      end
    end
  end

  assign req_valid_o = req_q;
  assign req_addr_o  = addr_q;
  assign req_len_o   = len_q;

  // R4
  rd_reserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RW'(used_a_i) + RW'(out_q)) <= RW'(DEPTH));
  // R4
  rd_rsp_expected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> out_q != '0);
  // R3
  rd_req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));
endmodule

// File: rtl/mcopy_wr_master.sv
module mcopy_wr_master #(
  parameter int AW    = 32,
  parameter int BURST = 8,
  parameter int DEPTH = 16,
  localparam int PW   = AW - 2,
  localparam int NW   = AW - 1,
  localparam int LW   = $clog2(BURST + 1),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] base_w_i,
  input  logic [NW-1:0] words_i,
  input  logic [CW-1:0] used_b_i,
  output logic          pop_o,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [AW-1:0] cmd_addr_o,
  output logic [LW-1:0] cmd_len_o,
  output logic          dat_valid_o,
  input  logic          dat_ready_i,
  output logic          last_o
);
  logic [NW-1:0] left_q;
  logic [PW-1:0] ptr_q;
  logic          cmd_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] blen;
  logic          launch;

  assign blen   = (left_q < NW'(BURST)) ? LW'(left_q) : LW'(BURST);
  assign launch = !cmd_q && (cnt_q == '0) && (left_q != '0) && (RW'(used_b_i) >= RW'(blen));

  assign dat_valid_o = (cnt_q != '0);
  assign pop_o       = dat_valid_o && dat_ready_i;
  assign last_o      = pop_o && (left_q == NW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      ptr_q  <= '0;
      cmd_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (start_i) begin
        left_q <= words_i;
        ptr_q  <= base_w_i;
      end else begin
        if (launch) ptr_q  <= ptr_q + PW'(blen);
        if (pop_o)  left_q <= left_q - NW'(1);
      end
      if (launch) begin
        cmd_q  <= 1'b1;
        addr_q <= {ptr_q, 2'b00};
        len_q  <= blen;
      end else if (cmd_q && cmd_ready_i) begin
        cmd_q <= 1'b0;
        cnt_q <= len_q;
      end else if (pop_o) begin
        cnt_q <= cnt_q - LW'(1);
      end
    end
  end

  assign cmd_valid_o = cmd_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_len_o   = len_q;

  // R5
  wr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> RW'(used_b_i) >= RW'(cmd_len_o));
  // R5
  wr_data_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o |-> used_b_i != '0);
  // R3
  wr_cmd_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_len_o));
endmodule

// File: rtl/mcopy_engine.sv
module mcopy_engine
  import mcopy_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BURST = 8,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(BURST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [AW-1:0] rd_req_addr_o,
  output logic [LW-1:0] rd_req_len_o,
  input  logic          rd_rsp_valid_i,
  input  logic [DW-1:0] rd_rsp_data_i,
  output logic          wr_req_valid_o,
  input  logic          wr_req_ready_i,
  output logic [AW-1:0] wr_req_addr_o,
  output logic [LW-1:0] wr_req_len_o,
  output logic          wr_dat_valid_o,
  input  logic          wr_dat_ready_i,
  output logic [DW-1:0] wr_dat_o,
  output logic          done_o
);
  localparam int PW = AW - 2;
  localparam int NW = AW - 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] src_beg_q, src_end_q, dst_q;
  logic          busy_q, done_q;
  logic [PW-1:0] beg_w, end_w;
  logic [NW-1:0] span;
  logic          start_req, accept, go;
  logic [CW-1:0] used_a, used_b;
  logic [DW-1:0] head_a, xf_word;
  logic          xfer, pop_b, wr_last;

  assign beg_w = src_beg_q[AW-1:2];
  assign end_w = src_end_q[AW-1:2];
  assign span  = (end_w >= beg_w) ? NW'(end_w - beg_w) + NW'(1) : '0;

  assign start_req = reg_we_i && (reg_sel_e'(reg_addr_i) == REG_CTRL) && reg_wdata_i[CTRL_START_BIT];
  assign accept    = start_req && !busy_q;
  assign go        = accept && (span != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_beg_q <= '0;
      src_end_q <= '0;
      dst_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (reg_we_i) begin
        unique case (reg_sel_e'(reg_addr_i))
          REG_SRC_BEG: src_beg_q <= reg_wdata_i;
          REG_SRC_END: src_end_q <= reg_wdata_i;
          REG_DST:     dst_q     <= reg_wdata_i;
          default:     ;
        endcase
      end
      if (accept) begin
        busy_q <= (span != '0);
        done_q <= (span == '0);
      end else if (wr_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr_i))
      REG_SRC_BEG: reg_rdata_o = src_beg_q;
      REG_SRC_END: reg_rdata_o = src_end_q;
      REG_DST:     reg_rdata_o = dst_q;
      default:     reg_rdata_o = {{(AW-2){1'b0}}, done_q, busy_q};
    endcase
  end

  assign done_o = done_q;

  mcopy_rd_master #(.AW(AW), .BURST(BURST), .DEPTH(DEPTH)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go),
    .base_w_i    (beg_w),
    .words_i     (span),
    .used_a_i    (used_a),
    .used_b_i    (used_b),
    .req_valid_o (rd_req_valid_o),
    .req_ready_i (rd_req_ready_i),
    .req_addr_o  (rd_req_addr_o),
    .req_len_o   (rd_req_len_o),
    .rsp_valid_i (rd_rsp_valid_i)
  );

  mcopy_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rd_rsp_valid_i),
    .data_i (rd_rsp_data_i),
    .pop_i  (xfer),
    .data_o (head_a),
    .used_o (used_a)
  );

  // A's non-empty drives B's push directly, through the transform
  assign xfer = (used_a != '0) && (used_b != CW'(DEPTH));

  mcopy_xform #(.DW(DW)) u_xform (
    .word_i (head_a),
    .word_o (xf_word)
  );

  mcopy_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (xfer),
    .data_i (xf_word),
    .pop_i  (pop_b),
    .data_o (wr_dat_o),
    .used_o (used_b)
  );

  mcopy_wr_master #(.AW(AW), .BURST(BURST), .DEPTH(DEPTH)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go),
    .base_w_i    (dst_q[AW-1:2]),
    .words_i     (span),
    .used_b_i    (used_b),
    .pop_o       (pop_b),
    .cmd_valid_o (wr_req_valid_o),
    .cmd_ready_i (wr_req_ready_i),
    .cmd_addr_o  (wr_req_addr_o),
    .cmd_len_o   (wr_req_len_o),
    .dat_valid_o (wr_dat_valid_o),
    .dat_ready_i (wr_dat_ready_i),
    .last_o      (wr_last)
  );

  // R1
  zero_len_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (span == '0) |=> done_o && !busy_q && !rd_req_valid_o);
  // R8
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_q && !wr_dat_valid_o);
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req && busy_q && !wr_last |=> busy_q);
endmodule

// File: tb/test_mcopy_engine.sv
module test_mcopy_engine;
  localparam int AW = 32, DW = 32, BURST = 8, DEPTH = 16;
  localparam int LW = $clog2(BURST + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [AW-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic rd_req_valid_o, rd_req_ready_i = 1'b0;
  logic [AW-1:0] rd_req_addr_o;
  logic [LW-1:0] rd_req_len_o;
  logic rd_rsp_valid_i = 1'b0;
  logic [DW-1:0] rd_rsp_data_i = '0;
  logic wr_req_valid_o, wr_req_ready_i = 1'b0;
  logic [AW-1:0] wr_req_addr_o;
  logic [LW-1:0] wr_req_len_o;
  logic wr_dat_valid_o, wr_dat_ready_i = 1'b0;
  logic [DW-1:0] wr_dat_o;
  logic done_o;

  mcopy_engine #(.AW(AW), .DW(DW), .BURST(BURST), .DEPTH(DEPTH)) i_mcopy_engine (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .rd_req_valid_o, .rd_req_ready_i, .rd_req_addr_o, .rd_req_len_o,
    .rd_rsp_valid_i, .rd_rsp_data_i,
    .wr_req_valid_o, .wr_req_ready_i, .wr_req_addr_o, .wr_req_len_o,
    .wr_dat_valid_o, .wr_dat_ready_i, .wr_dat_o, .done_o
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int cur_src_w = 0, cur_dst_w = 0, cur_n = 0;
  int rd_words = 0, wr_cmd_words = 0, wr_words = 0;
  int mode = 0;
  bit hold_wr = 1'b0, last_seen = 1'b0;
  int pend [256];
  int ph = 0, pt = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] src_fn(input int w);
    return 32'(w) * 32'h9E3779B1 + 32'h01234567;
  endfunction

  function automatic logic [31:0] xf(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    for (int k = 0; k < 16; k++) r[8+k] = w[23-k];
    return r;
  endfunction

  // memory-side responder
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        rd_req_ready_i = 0; rd_rsp_valid_i = 0; wr_req_ready_i = 0; wr_dat_ready_i = 0;
        continue;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (last_seen) begin
        chk(done_o === 1'b1, "R8 done one cycle after last write", done_o, 1);
        last_seen = 0;
      end
      rd_req_ready_i = (mode == 0) || lf[0];
      if (rd_req_valid_o && rd_req_ready_i) begin
        chk(rd_req_addr_o == 32'((cur_src_w + rd_words) * 4), "R3 read address",
            rd_req_addr_o, 32'((cur_src_w + rd_words) * 4));
        chk(int'(rd_req_len_o) == mn(BURST, cur_n - rd_words), "R3 read length",
            rd_req_len_o, mn(BURST, cur_n - rd_words));
        for (int i = 0; i < int'(rd_req_len_o); i++) begin
          pend[pt % 256] = cur_src_w + rd_words + i;
          pt++;
        end
        rd_words += int'(rd_req_len_o);
      end
      if (pt != ph && ((mode == 0) || lf[1])) begin
        rd_rsp_valid_i = 1;
        rd_rsp_data_i  = src_fn(pend[ph % 256]);
        ph++;
      end else begin
        rd_rsp_valid_i = 0;
      end
      wr_req_ready_i = !hold_wr && ((mode == 0) || lf[2]);
      if (wr_req_valid_o && wr_req_ready_i) begin
        chk(wr_req_addr_o == 32'((cur_dst_w + wr_cmd_words) * 4), "R3 write address",
            wr_req_addr_o, 32'((cur_dst_w + wr_cmd_words) * 4));
        chk(int'(wr_req_len_o) == mn(BURST, cur_n - wr_cmd_words), "R3 write length",
            wr_req_len_o, mn(BURST, cur_n - wr_cmd_words));
        wr_cmd_words += int'(wr_req_len_o);
      end
      wr_dat_ready_i = (mode == 0) || lf[3];
      if (wr_dat_valid_o && wr_dat_ready_i) begin
        chk(wr_dat_o == xf(src_fn(cur_src_w + wr_words)), "R6 transformed data",
            wr_dat_o, xf(src_fn(cur_src_w + wr_words)));
        chk(wr_words < wr_cmd_words, "R5 data only inside accepted burst", wr_words, wr_cmd_words);
        chk(done_o === 1'b0, "R8 done not early", done_o, 0);
        wr_words++;
        if (wr_words == cur_n) last_seen = 1;
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic setup(input logic [31:0] beg_b, input logic [31:0] end_b,
                       input logic [31:0] dst_b, input int n, input int m);
    cur_src_w = int'(beg_b[31:2]); cur_dst_w = int'(dst_b[31:2]); cur_n = n; mode = m;
    rd_words = 0; wr_cmd_words = 0; wr_words = 0; ph = 0; pt = 0; last_seen = 0;
    reg_write(2'd0, beg_b);
    reg_write(2'd1, end_b);
    reg_write(2'd2, dst_b);
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (done_o !== 1'b1 && k < 20000) begin
      @(negedge clk_i);
      k++;
    end
    chk(done_o === 1'b1, tag, done_o, 1);
  endtask

  task automatic finish_checks(input int n);
    logic [31:0] st;
    repeat (2) @(negedge clk_i);
    chk(wr_words == n, "R6 words written", wr_words, n);
    chk(rd_words == n, "R1 words read", rd_words, n);
    chk(ph == pt, "R4 all read data returned", ph, pt);
    reg_read(2'd3, st);
    chk(st == 32'h2, "R8 status done and idle", st, 32'h2);
  endtask

  task automatic copy(input logic [31:0] beg_b, input logic [31:0] end_b,
                      input logic [31:0] dst_b, input int n, input int m);
    logic [31:0] st;
    setup(beg_b, end_b, dst_b, n, m);
    reg_write(2'd3, 32'h1);
    chk(done_o === 1'b0, "R8 start clears done", done_o, 0);
    reg_read(2'd3, st);
    chk(st == 32'h1, "R8 busy after start", st, 32'h1);
    wait_done("R8 copy completes");
    finish_checks(n);
  endtask

  initial begin
    logic [31:0] st;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R10 reset state
    chk(done_o === 1'b0, "R10 done low", done_o, 0);
    chk(rd_req_valid_o === 1'b0, "R10 read request low", rd_req_valid_o, 0);
    chk(wr_req_valid_o === 1'b0, "R10 write command low", wr_req_valid_o, 0);
    chk(wr_dat_valid_o === 1'b0, "R10 write data low", wr_dat_valid_o, 0);
    reg_read(2'd3, st);
    chk(st == 32'h0, "R10 status zero", st, 0);

    // R2 register readback
    reg_write(2'd0, 32'hDEAD_BEEF);
    reg_write(2'd1, 32'h1234_5678);
    reg_write(2'd2, 32'hCAFE_F00D);
    reg_read(2'd0, st); chk(st == 32'hDEAD_BEEF, "R2 begin readback", st, 32'hDEAD_BEEF);
    reg_read(2'd1, st); chk(st == 32'h1234_5678, "R2 end readback", st, 32'h1234_5678);
    reg_read(2'd2, st); chk(st == 32'hCAFE_F00D, "R2 dest readback", st, 32'hCAFE_F00D);

    // R1 end word below begin: zero words, done next cycle
    setup(32'h400, 32'h3FC, 32'h800, 0, 0);
    reg_write(2'd3, 32'h1);
    chk(done_o === 1'b1, "R1 zero count done next cycle", done_o, 1);
    reg_read(2'd3, st);
    chk(st == 32'h2, "R1 zero count not busy", st, 32'h2);
    repeat (10) @(negedge clk_i);
    chk(rd_words == 0 && wr_cmd_words == 0, "R1 zero count issues nothing", rd_words + wr_cmd_words, 0);
    setup(32'h8000, 32'h10, 32'h800, 0, 0);
    reg_write(2'd3, 32'h1);
    repeat (10) @(negedge clk_i);
    chk(rd_words == 0 && wr_cmd_words == 0 && done_o === 1'b1, "R1 far-below end", rd_words, 0);

    // sweep of counts around the burst boundary, both ready patterns
    for (int n = 1; n <= 20; n++) begin
      copy(32'h1000 + 32'(n) * 256, 32'h1000 + 32'(n) * 256 + 32'(4 * (n - 1)),
           32'h8000 + 32'(n) * 512, n, n % 2);
    end
    copy(32'h3000, 32'h3000 + 32'(4 * 39), 32'h9000, 40, 1);

    // R1 low address bits ignored: begin 0x2002 -> word 0x800, end 0x2011 -> word 0x804
    copy(32'h2002, 32'h2011, 32'h5003, 5, 0);

    // R7 read side proceeds with write commands stalled
    hold_wr = 1;
    setup(32'h4000, 32'h4000 + 32'(4 * 39), 32'hA000, 40, 0);
    reg_write(2'd3, 32'h1);
    repeat (200) @(negedge clk_i);
    chk(wr_cmd_words == 0, "R7 no write command accepted", wr_cmd_words, 0);
    chk(rd_words >= DEPTH, "R7 read side filled FIFOs", rd_words, DEPTH);
    chk(rd_words <= 2 * DEPTH, "R4 reads bounded by FIFO room", rd_words, 2 * DEPTH);
    hold_wr = 0;
    wait_done("R7 copy completes after release");
    finish_checks(40);

    // R9 start while busy ignored
    setup(32'h6000, 32'h6000 + 32'(4 * 29), 32'hB000, 30, 1);
    reg_write(2'd3, 32'h1);
    repeat (15) @(negedge clk_i);
    reg_write(2'd0, 32'h7000);
    reg_write(2'd1, 32'h7004);
    reg_write(2'd3, 32'h1);
    chk(done_o === 1'b0, "R9 busy start did not complete", done_o, 0);
    reg_read(2'd3, st);
    chk(st == 32'h1, "R9 still busy", st, 32'h1);
    wait_done("R9 original copy completes");
    finish_checks(30);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule